// File: doc/BRIEF.md
# Multi-Mode Pulse-Width Modulator

This block drives one pulse-width modulated output from a 10 ns tick. A mode selector chooses one of three hardware waveform styles, or holds the output idle. In standard mode the period is fixed and the duty value sets how many ticks are high. In variable-frequency mode two period values set the lengths of the high and low phases independently. In fast mode the duty value is encoded as a single one-tick pulse set inside a longer steady level, so the output frequency changes with the duty value.

Every period is built from two phases: a first phase and a second phase, each with its own level and length. The mode, duty and period inputs can change at any time. They are sampled only when the current period ends, so a period that has started always finishes with the settings it started with. While the output is idle, a period ends on every clock, so new settings are picked up at the next edge.

Top module: `pwm_multimode`

## Requirements
- R1: `mode_sel` encodes 0 as idle, 1 as standard, 2 as fast and 3 as variable-frequency. The idle code and every code from 4 to 7 hold `pwm_out` low.
- R2: In standard mode a period lasts 2^DUTY_W ticks. It is high for `duty` ticks and low for the rest, with the high ticks first. A duty of 0 gives a constant low.
- R3: In variable-frequency mode each period is high for `per_hi`+1 ticks and then low for `per_lo`+1 ticks.
- R4: In fast mode with 0 < `duty` < 2^(DUTY_W-1), each period is one high tick followed by a low phase of round((M-d)/d) ticks, where M = 2^DUTY_W-1 and halves round up.
- R5: In fast mode with 2^(DUTY_W-1) <= `duty` < M, each period is one low tick followed by a high phase of round(d/(M-d)) ticks.
- R6: In fast mode a duty of 0 gives a constant low and a duty of M gives a constant high.
- R7: In fast mode the long phase is clamped to FAST_CLAMP ticks.
- R8: Changes to `mode_sel`, `duty`, `per_lo` and `per_hi` take effect only at the first tick of the next period. The active period completes with the settings it started with.
- R9: While `rst_n` is low, `pwm_out` is low and the sequencer is idle. The settings present at the first rising edge after reset is released start the first period, and its first tick is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 ns tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Waveform style selector |
| duty | input | DUTY_W | Duty value for standard and fast modes |
| per_lo | input | PER_W | Low-phase length minus one, variable-frequency mode |
| per_hi | input | PER_W | High-phase length minus one, variable-frequency mode |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench keeps DUTY_W at 8 and PER_W at 13, so the 256-tick standard period and the longest variable-frequency high phase of 8192 ticks are both exercised. It lowers FAST_CLAMP to 200. With an 8-bit duty the longest rounded fast phase is 254 ticks, which never reaches the default limit of 255, so the lower limit is the only way duties of 1 and 254 can hit the clamp. Each waveform is compared tick by tick over two full periods, and settings are changed mid-period to check that a change waits for the period boundary.

// File: rtl/pwm_mm_pkg.sv
package pwm_mm_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      PM_OFF  = 3'd0,
      PM_STD  = 3'd1,
      PM_FAST = 3'd2,
      PM_VAR  = 3'd3
   } pm_mode_e;

   // Level and enable part of a two-phase period description
   typedef struct packed {
      logic     run;
      pm_mode_e mode;
      logic     lvl_a;
      logic     lvl_b;
   } shape_ctl_t;

endpackage

// File: rtl/pwm_fast_ratio.sv
module pwm_fast_ratio
   import pwm_mm_pkg::*;
#(
   parameter int DUTY_W     = 8,
   parameter int LEN_W      = 14,
   parameter int FAST_CLAMP = 255
) (
   input  logic [DUTY_W-1:0] duty,
   output logic              lvl_a,
   output logic [LEN_W-1:0]  len_a,
   output logic              lvl_b,
   output logic [LEN_W-1:0]  len_b
);

   localparam int DMAX = (1 << DUTY_W) - 1;
   localparam int W2   = DUTY_W + 2;

   logic [W2-1:0]    num;
   logic [W2-1:0]    den;
   logic [W2-1:0]    quo;
   logic [LEN_W-1:0] quo_ext;

   always_comb begin
      num     = '0;
      den     = W2'(1);
      quo     = '0;
      quo_ext = '0;
      lvl_a   = 1'b1;
      lvl_b   = 1'b0;
      len_a   = '0;
      len_b   = LEN_W'(1);
      if (duty == '0) begin
         lvl_a = 1'b0;
         lvl_b = 1'b0;
      end else if (duty == DUTY_W'(DMAX)) begin
         lvl_a = 1'b1;
         lvl_b = 1'b1;
      end else begin
         if (!duty[DUTY_W-1]) begin
            num   = W2'(DMAX) - W2'(duty);
            den   = W2'(duty);
            lvl_a = 1'b1;
            lvl_b = 1'b0;
         end else begin
            num   = W2'(duty);
            den   = W2'(DMAX) - W2'(duty);
            lvl_a = 1'b0;
            lvl_b = 1'b1;
         end
         // round to nearest: (2n + m) / (2m)
         quo     = ((num << 1) + den) / (den << 1);
         quo_ext = LEN_W'(quo);
         len_a   = LEN_W'(1);
         len_b   = (quo_ext > LEN_W'(FAST_CLAMP)) ? LEN_W'(FAST_CLAMP) : quo_ext;
      end
   end

endmodule

// File: rtl/pwm_shape_decode.sv
module pwm_shape_decode
   import pwm_mm_pkg::*;
#(
   parameter int DUTY_W     = 8,
   parameter int PER_W      = 13,
   parameter int LEN_W      = 14,
   parameter int FAST_CLAMP = 255
) (
   input  logic [MODE_W-1:0] mode_in,
   input  logic [DUTY_W-1:0] duty,
   input  logic [PER_W-1:0]  per_lo,
   input  logic [PER_W-1:0]  per_hi,
   output shape_ctl_t        ctl,
   output logic [LEN_W-1:0]  len_a,
   output logic [LEN_W-1:0]  len_b
);

   localparam int STD_LEN = 1 << DUTY_W;

   logic             f_lvl_a;
   logic             f_lvl_b;
   logic [LEN_W-1:0] f_len_a;
   logic [LEN_W-1:0] f_len_b;

   pwm_fast_ratio #(
      .DUTY_W     (DUTY_W),
      .LEN_W      (LEN_W),
      .FAST_CLAMP (FAST_CLAMP)
   ) u_ratio (
      .duty  (duty),
      .lvl_a (f_lvl_a),
      .len_a (f_len_a),
      .lvl_b (f_lvl_b),
      .len_b (f_len_b)
   );

   always_comb begin
      ctl.run   = 1'b0;
      ctl.mode  = PM_OFF;
      ctl.lvl_a = 1'b0;
      ctl.lvl_b = 1'b0;
      len_a     = '0;
      len_b     = LEN_W'(1);
      case (mode_in)
         PM_STD: begin
            ctl.run   = 1'b1;
            ctl.mode  = PM_STD;
            ctl.lvl_a = 1'b1;
            ctl.lvl_b = 1'b0;
            len_a     = LEN_W'(duty);
            len_b     = LEN_W'(STD_LEN) - LEN_W'(duty);
         end
         PM_FAST: begin
            ctl.run   = 1'b1;
            ctl.mode  = PM_FAST;
            ctl.lvl_a = f_lvl_a;
            ctl.lvl_b = f_lvl_b;
            len_a     = f_len_a;
            len_b     = f_len_b;
         end
         PM_VAR: begin
            ctl.run   = 1'b1;
            ctl.mode  = PM_VAR;
            ctl.lvl_a = 1'b1;
            ctl.lvl_b = 1'b0;
            len_a     = LEN_W'(per_hi) + LEN_W'(1);
            len_b     = LEN_W'(per_lo) + LEN_W'(1);
         end
         default: begin
            ctl.run = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
   import pwm_mm_pkg::*;
#(
   parameter int LEN_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  shape_ctl_t       nxt_ctl,
   input  logic [LEN_W-1:0] nxt_len_a,
   input  logic [LEN_W-1:0] nxt_len_b,
   output shape_ctl_t       act_ctl,
   output logic [LEN_W-1:0] act_len_a,
   output logic [LEN_W-1:0] act_len_b,
   output logic             period_end,
   output logic             pwm_out
);

   logic             in_b;
   logic [LEN_W-1:0] cnt;
   logic             a_done;

   assign a_done     = !in_b && (cnt == act_len_a - LEN_W'(1));
   assign period_end = !act_ctl.run || (in_b && (cnt == act_len_b - LEN_W'(1)));
   assign pwm_out    = act_ctl.run && (in_b ? act_ctl.lvl_b : act_ctl.lvl_a);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_ctl   <= '{run: 1'b0, mode: PM_OFF, lvl_a: 1'b0, lvl_b: 1'b0};
         act_len_a <= '0;
         act_len_b <= LEN_W'(1);
         in_b      <= 1'b1;
         cnt       <= '0;
      end else if (period_end) begin
         act_ctl   <= nxt_ctl;
         act_len_a <= nxt_len_a;
         act_len_b <= nxt_len_b;
         in_b      <= (nxt_len_a == '0);
         cnt       <= '0;
      end else if (a_done) begin
         in_b <= 1'b1;
         cnt  <= '0;
      end else begin
         cnt <= cnt + LEN_W'(1);
      end
   end

   // the tick counter never leaves the phase it belongs to
   p_cnt_in_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      act_ctl.run |-> (in_b ? (cnt < act_len_b) : (cnt < act_len_a)));

   // an idle sequencer sits in the second phase with a cleared counter
   p_idle_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !act_ctl.run |-> (in_b && cnt == '0 && !pwm_out));

endmodule

// File: rtl/pwm_multimode.sv
module pwm_multimode
   import pwm_mm_pkg::*;
#(
   parameter int DUTY_W     = 8,
   parameter int PER_W      = 13,
   parameter int FAST_CLAMP = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_sel,
   input  logic [DUTY_W-1:0] duty,
   input  logic [PER_W-1:0]  per_lo,
   input  logic [PER_W-1:0]  per_hi,
   output logic              pwm_out
);

   localparam int WIDE    = (PER_W > DUTY_W + 1) ? PER_W : DUTY_W + 1;
   localparam int LEN_W   = WIDE + 1;
   localparam int STD_LEN = 1 << DUTY_W;

   generate
      if (DUTY_W < 2 || DUTY_W > 16) begin : g_bad_duty
         $error("DUTY_W must lie in 2..16");
      end
      if (PER_W < 1 || PER_W > 24) begin : g_bad_per
         $error("PER_W must lie in 1..24");
      end
      if (FAST_CLAMP < 1 || FAST_CLAMP >= (1 << LEN_W)) begin : g_bad_clamp
         $error("FAST_CLAMP must be positive and fit the length counter");
      end
      if (MODE_W != 3) begin : g_bad_mode
         $error("mode selector width must be 3");
      end
   endgenerate

   shape_ctl_t       nxt_ctl;
   logic [LEN_W-1:0] nxt_len_a;
   logic [LEN_W-1:0] nxt_len_b;
   shape_ctl_t       act_ctl;
   logic [LEN_W-1:0] act_len_a;
   logic [LEN_W-1:0] act_len_b;
   logic             period_end;

   pwm_shape_decode #(
      .DUTY_W     (DUTY_W),
      .PER_W      (PER_W),
      .LEN_W      (LEN_W),
      .FAST_CLAMP (FAST_CLAMP)
   ) u_decode (
      .mode_in (mode_sel),
      .duty    (duty),
      .per_lo  (per_lo),
      .per_hi  (per_hi),
      .ctl     (nxt_ctl),
      .len_a   (nxt_len_a),
      .len_b   (nxt_len_b)
   );

   pwm_phase_seq #(
      .LEN_W (LEN_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .nxt_ctl    (nxt_ctl),
      .nxt_len_a  (nxt_len_a),
      .nxt_len_b  (nxt_len_b),
      .act_ctl    (act_ctl),
      .act_len_a  (act_len_a),
      .act_len_b  (act_len_b),
      .period_end (period_end),
      .pwm_out    (pwm_out)
   );

   // reserved selector codes leave the output low once they are taken
   p_reserved_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && mode_sel[2]) |=> !pwm_out);

   // a standard period always spans the full duty range
   p_std_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && mode_sel == PM_STD) |=>
         (act_len_a + act_len_b == LEN_W'(STD_LEN)));

   // variable-frequency phases are the period inputs plus one
   p_var_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && mode_sel == PM_VAR) |=>
         (act_len_a == LEN_W'($past(per_hi)) + LEN_W'(1) &&
          act_len_b == LEN_W'($past(per_lo)) + LEN_W'(1)));

   // a fast period that has a first phase has exactly one tick in it
   p_fast_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ctl.run && act_ctl.mode == PM_FAST && act_len_a != '0) |->
         (act_len_a == LEN_W'(1) && act_ctl.lvl_a != act_ctl.lvl_b));

   // the long fast phase never exceeds the clamp
   p_fast_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ctl.run && act_ctl.mode == PM_FAST) |->
         (act_len_b <= LEN_W'(FAST_CLAMP)));

   // active settings only move at a period boundary
   p_hold_mid_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(period_end) |->
         ($stable(act_ctl) && $stable(act_len_a) && $stable(act_len_b)));

endmodule

// File: tb/sim_pwm_multimode.sv
module sim_pwm_multimode;

   localparam int DUTY_W = 8;
   localparam int PER_W  = 13;
   localparam int CLAMP  = 200;
   localparam int NV     = 18;

   typedef struct packed {
      logic [2:0]  m;
      logic [7:0]  d;
      logic [12:0] lo;
      logic [12:0] hi;
      logic        la;
      logic [13:0] na;
      logic        lb;
      logic [13:0] nb;
   } vec_t;

   // mode, duty, lo, hi, first level, first length, second level, second length
   localparam vec_t VT [NV] = '{
      '{3'd1, 8'd64,  13'd0, 13'd0,    1'b1, 14'd64,   1'b0, 14'd192},
      '{3'd1, 8'd0,   13'd0, 13'd0,    1'b1, 14'd0,    1'b0, 14'd256},
      '{3'd1, 8'd255, 13'd0, 13'd0,    1'b1, 14'd255,  1'b0, 14'd1},
      '{3'd3, 8'd0,   13'd3, 13'd5,    1'b1, 14'd6,    1'b0, 14'd4},
      '{3'd3, 8'd0,   13'd0, 13'd0,    1'b1, 14'd1,    1'b0, 14'd1},
      '{3'd3, 8'd0,   13'd2, 13'd8191, 1'b1, 14'd8192, 1'b0, 14'd3},
      '{3'd2, 8'd1,   13'd0, 13'd0,    1'b1, 14'd1,    1'b0, 14'd200},
      '{3'd2, 8'd127, 13'd0, 13'd0,    1'b1, 14'd1,    1'b0, 14'd1},
      '{3'd2, 8'd64,  13'd0, 13'd0,    1'b1, 14'd1,    1'b0, 14'd3},
      '{3'd2, 8'd20,  13'd0, 13'd0,    1'b1, 14'd1,    1'b0, 14'd12},
      '{3'd2, 8'd200, 13'd0, 13'd0,    1'b0, 14'd1,    1'b1, 14'd4},
      '{3'd2, 8'd236, 13'd0, 13'd0,    1'b0, 14'd1,    1'b1, 14'd12},
      '{3'd2, 8'd128, 13'd0, 13'd0,    1'b0, 14'd1,    1'b1, 14'd1},
      '{3'd2, 8'd254, 13'd0, 13'd0,    1'b0, 14'd1,    1'b1, 14'd200},
      '{3'd2, 8'd0,   13'd0, 13'd0,    1'b0, 14'd0,    1'b0, 14'd1},
      '{3'd2, 8'd255, 13'd0, 13'd0,    1'b0, 14'd0,    1'b1, 14'd1},
      '{3'd4, 8'd200, 13'd5, 13'd5,    1'b0, 14'd0,    1'b0, 14'd1},
      '{3'd0, 8'd200, 13'd5, 13'd5,    1'b0, 14'd0,    1'b0, 14'd1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        mode_sel = 3'd0;
   logic [DUTY_W-1:0] duty = '0;
   logic [PER_W-1:0]  per_lo = '0;
   logic [PER_W-1:0]  per_hi = '0;
   logic              pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pwm_multimode #(
      .DUTY_W     (DUTY_W),
      .PER_W      (PER_W),
      .FAST_CLAMP (CLAMP)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .duty     (duty),
      .per_lo   (per_lo),
      .per_hi   (per_hi),
      .pwm_out  (pwm_out)
   );

   function automatic string req_tag(input logic [2:0] m, input logic [7:0] d);
      if (m == 3'd1) return "R2";
      if (m == 3'd3) return "R3";
      if (m == 3'd2) begin
         if (d == 8'd0 || d == 8'd255) return "R6";
         if (d == 8'd1 || d == 8'd254) return "R7";
         if (d < 8'd128) return "R4";
         return "R5";
      end
      return "R1";
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reset, apply settings, release; the next rising edge starts the period
   task automatic start_with(input vec_t v);
      @(negedge clk);
      rst_n    = 1'b0;
      mode_sel = v.m;
      duty     = v.d;
      per_lo   = v.lo;
      per_hi   = v.hi;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
   endtask

   initial begin
      // R9: output stays low in reset even with settings that would drive it high
      mode_sel = 3'd1;
      duty     = 8'd255;
      repeat (3) @(negedge clk);
      check("R9", "output held in reset", int'(pwm_out), 0);

      // table walk: two full periods compared tick by tick
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         int span, ticks, bad, bad_t, bad_a, bad_e;
         v     = VT[i];
         span  = int'(v.na) + int'(v.nb);
         ticks = (2 * span < 16) ? 16 : 2 * span;
         bad   = 0;
         bad_t = 0;
         bad_a = 0;
         bad_e = 0;
         start_with(v);
         for (int t = 0; t < ticks; t++) begin
            int p, e;
            @(negedge clk);
            p = t % span;
            e = (p < int'(v.na)) ? int'(v.la) : int'(v.lb);
            if (int'(pwm_out) != e && bad == 0) begin
               bad   = 1;
               bad_t = t;
               bad_a = int'(pwm_out);
               bad_e = e;
            end
         end
         checks++;
         if (bad != 0) begin
            fails++;
            $display("FAIL %s vector %0d mode %0d duty %0d tick %0d: actual %0d expected %0d",
                     req_tag(v.m, v.d), i, v.m, v.d, bad_t, bad_a, bad_e);
         end
      end

      // R8: mid-period changes wait for the period boundary
      begin
         int bad_old, bad_new, bad_off;
         bad_old = 0;
         bad_new = 0;
         bad_off = 0;
         start_with(VT[0]);
         for (int t = 0; t < 540; t++) begin
            int e;
            @(negedge clk);
            if (t < 256)      e = (t < 64) ? 1 : 0;
            else if (t < 512) e = ((t - 256) < 200) ? 1 : 0;
            else              e = 0;
            if (int'(pwm_out) != e) begin
               if (t < 256)      bad_old++;
               else if (t < 512) bad_new++;
               else              bad_off++;
            end
            if (t == 10)  duty = 8'd200;
            if (t == 300) mode_sel = 3'd0;
         end
         check("R8", "old duty kept until period end, mismatching ticks", bad_old, 0);
         check("R8", "new duty applied at next period, mismatching ticks", bad_new, 0);
         check("R8", "idle taken only at period end, mismatching ticks", bad_off, 0);
      end

      // R9: asynchronous reset drops a high output at once
      start_with(VT[2]);
      @(negedge clk);
      check("R9", "first tick high before reset", int'(pwm_out), 1);
      #2 rst_n = 1'b0;
      #1;
      check("R9", "output low right after reset assertion", int'(pwm_out), 0);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule